// File: doc/BRIEF.md
# Quadrature Position Counter

This block turns the two phase-shifted channels of an incremental rotary or linear encoder into a signed-direction position count. Both channels pass through a synchronizer. Every edge of either channel is decoded (four counts per encoder line), and each legal step moves the counter by one, up or down. A per-channel inversion control flips the sense of a channel, so the counting direction can be reversed without rewiring.

The counter runs between zero and a programmable reload limit and wraps at either end. Every wrap raises a sticky update flag, which software clears by writing zero to it. When the mirror option is on, the most significant bit of the counter read value carries the update flag instead of the counter bit. A single read then returns both the position and whether a roll-over happened since the last clear.

A capture strobe, typically a periodic pulse from elsewhere in the system, copies the live count into a holding register so the position can be sampled at fixed intervals.

Top module: `qenc_counter`

## Requirements
- R1: Channel levels are taken as the pair {A,B} after inversion. The forward order is 00, 10, 11, 01, then back to 00. A change to the next pair in that order increments the counter by one. The count changes on the third rising clock edge after the input change.
- R2: A change to the previous pair in the forward order decrements the counter by one.
- R3: A change in which both channels toggle at once is ignored: counter and direction bit stay unchanged.
- R4: Setting `inv_a` (or `inv_b`) complements that channel before decoding, which reverses the counting direction for the same physical motion. Toggling an inversion control while the channels are still produces no count.
- R5: Counting up from a value equal to `arr_val` loads zero and sets `upd_flag`.
- R6: Counting down from zero loads `arr_val` and sets `upd_flag`.
- R7: `upd_flag` stays set until a status write (`stat_we`) with `wdata[0]`=0. A status write with `wdata[0]`=1 has no effect. If a clear and a wrap fall on the same clock edge, the flag remains set.
- R8: With `remap_en`=1, bit CNT_W-1 of `cnt_rd` equals `upd_flag` in the same cycle, and the lower bits are the counter.
- R9: With `remap_en`=0, `cnt_rd` returns the full counter. A counter write (`cnt_we`) loads all bits, including the top bit, whatever the state of `remap_en`, and has priority over a step.
- R10: A one-cycle `cap_strobe` copies the counter value held before that edge into `cap_val`.
- R11: `dir_down` is 1 after a valid decrementing step and 0 after a valid incrementing step. Otherwise it holds its value.
- R12: During and after reset: counter 0, `arr_val` all ones, `cap_val` 0, `upd_flag` 0, `dir_down` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| inv_a | input | 1 | Complement channel A before decoding |
| inv_b | input | 1 | Complement channel B before decoding |
| remap_en | input | 1 | Mirror update flag into counter read MSB |
| cnt_we | input | 1 | Load counter from wdata |
| arr_we | input | 1 | Load reload limit from wdata |
| stat_we | input | 1 | Status write; wdata[0]=0 clears the update flag |
| wdata | input | CNT_W | Write data |
| cap_strobe | input | 1 | Capture the counter into cap_val |
| cnt_rd | output | CNT_W | Counter read value (optionally with mirrored flag) |
| arr_val | output | CNT_W | Reload limit |
| cap_val | output | CNT_W | Captured count |
| upd_flag | output | 1 | Sticky wrap flag |
| dir_down | output | 1 | Direction of last valid step (1 = down) |

## Verification
The hardest case to reach from the ports is a flag clear that lands on the same clock edge as a wrap. The wrap edge is set by the synchronizer and decoder pipeline, not by the bench. The stimulus places the counter at the reload limit, changes the channels one step forward, and counts exactly two falling edges before raising `stat_we` with `wdata[0]` low. The write is then sampled on the same rising edge that performs the wrap. Random stepping with a small reload limit, mixed with polarity flips, mirror toggles and double-channel glitches, covers the remaining combinations.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], din[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign dout[i] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  a_s,
  input  logic  b_s,
  input  logic  inv_a,
  input  logic  inv_b,
  output step_e step
);
  // Previous raw levels; inversion is applied to both sides of the
  // comparison so a polarity change alone never looks like an edge.
  logic prev_a_q, prev_b_q;
  logic ea_cur, eb_prev;
  logic chg_a, chg_b;

  always_comb begin
    ea_cur  = a_s ^ inv_a;
    eb_prev = prev_b_q ^ inv_b;
    chg_a   = a_s ^ prev_a_q;
    chg_b   = b_s ^ prev_b_q;
    step    = STEP_NONE;
    if (chg_a ^ chg_b) begin
      step = (ea_cur ^ eb_prev) ? STEP_UP : STEP_DN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a_q <= 1'b0;
      prev_b_q <= 1'b0;
    end else begin
      prev_a_q <= a_s;
      prev_b_q <= b_s;
    end
  end
endmodule

// File: rtl/qenc_core.sv
module qenc_core
  import qenc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_e            step,
  input  logic             cnt_we,
  input  logic             arr_we,
  input  logic             stat_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             cap_strobe,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] arr_q,
  output logic [CNT_W-1:0] cap_q,
  output logic             flag_q,
  output logic             dir_q
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             flag_d;
  logic             flag_en;
  logic             dir_d;
  logic             dir_en;
  logic             wrap;
  logic             clr_req;

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (cnt_we) begin
      cnt_d = wdata;
    end else begin
      unique case (step)
        STEP_UP: begin
          if (cnt_q == arr_q) begin
            cnt_d = CNT_ZERO;
            wrap  = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_ONE;
          end
        end
        STEP_DN: begin
          if (cnt_q == CNT_ZERO) begin
            cnt_d = arr_q;
            wrap  = 1'b1;
          end else begin
            cnt_d = cnt_q - CNT_ONE;
          end
        end
        default: cnt_d = cnt_q;
      endcase
    end
    cnt_en = cnt_we || (step != STEP_NONE);
  end

  always_comb begin
    clr_req = stat_we && !wdata[0];
    flag_d  = wrap ? 1'b1 : (clr_req ? 1'b0 : flag_q);
    flag_en = wrap || clr_req;
    dir_en  = (step != STEP_NONE);
    dir_d   = (step == STEP_DN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      arr_q  <= '1;
      cap_q  <= '0;
      flag_q <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      if (cnt_en)     cnt_q  <= cnt_d;
      if (arr_we)     arr_q  <= wdata;
      if (cap_strobe) cap_q  <= cnt_q;
      if (flag_en)    flag_q <= flag_d;
      if (dir_en)     dir_q  <= dir_d;
    end
  end
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             inv_a,
  input  logic             inv_b,
  input  logic             remap_en,
  input  logic             cnt_we,
  input  logic             arr_we,
  input  logic             stat_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             cap_strobe,
  output logic [CNT_W-1:0] cnt_rd,
  output logic [CNT_W-1:0] arr_val,
  output logic [CNT_W-1:0] cap_val,
  output logic             upd_flag,
  output logic             dir_down
);
  localparam int MSB = CNT_W - 1;

  // Reset: asynchronous assertion, synchronous release.
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[RST_STAGES-1];

  logic [1:0] enc_sync;
  logic       a_s, b_s;
  step_e      step;
  logic [CNT_W-1:0] cnt_q;
  logic       flag_q;

  qenc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   ({enc_b, enc_a}),
    .dout  (enc_sync)
  );
  assign a_s = enc_sync[0];
  assign b_s = enc_sync[1];

  qenc_decode u_dec (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .a_s   (a_s),
    .b_s   (b_s),
    .inv_a (inv_a),
    .inv_b (inv_b),
    .step  (step)
  );

  qenc_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .step       (step),
    .cnt_we     (cnt_we),
    .arr_we     (arr_we),
    .stat_we    (stat_we),
    .wdata      (wdata),
    .cap_strobe (cap_strobe),
    .cnt_q      (cnt_q),
    .arr_q      (arr_val),
    .cap_q      (cap_val),
    .flag_q     (flag_q),
    .dir_q      (dir_down)
  );

  assign upd_flag = flag_q;

  always_comb begin
    cnt_rd = cnt_q;
    if (remap_en) cnt_rd[MSB] = flag_q;
  end
endmodule

// File: rtl/qenc_counter_chk.sv
module qenc_counter_chk
  import qenc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             a_s,
  input logic             b_s,
  input step_e            step,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] arr_val,
  input logic [CNT_W-1:0] cap_val,
  input logic             upd_flag,
  input logic             dir_down,
  input logic             cnt_we,
  input logic             stat_we,
  input logic [CNT_W-1:0] wdata,
  input logic             cap_strobe,
  input logic             remap_en,
  input logic [CNT_W-1:0] cnt_rd
);
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step == STEP_NONE && !cnt_we) |=> (cnt_q == $past(cnt_q)));

  assert_double_edge_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (a_s != $past(a_s) && b_s != $past(b_s)) |-> (step == STEP_NONE));

  assert_wrap_up_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step == STEP_UP && !cnt_we && cnt_q == arr_val) |=> (cnt_q == '0 && upd_flag));

  assert_wrap_dn_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step == STEP_DN && !cnt_we && cnt_q == '0) |=> (cnt_q == $past(arr_val) && upd_flag));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_flag && !(stat_we && !wdata[0])) |=> upd_flag);

  assert_mirror_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    remap_en |-> (cnt_rd[CNT_W-1] == upd_flag && cnt_rd[CNT_W-2:0] == cnt_q[CNT_W-2:0]));

  assert_native_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !remap_en |-> (cnt_rd == cnt_q));

  assert_capture_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cap_strobe |=> (cap_val == $past(cnt_q)));

  assert_dir_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step == STEP_DN) |=> dir_down);
endmodule

bind qenc_counter qenc_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .a_s        (a_s),
  .b_s        (b_s),
  .step       (step),
  .cnt_q      (cnt_q),
  .arr_val    (arr_val),
  .cap_val    (cap_val),
  .upd_flag   (upd_flag),
  .dir_down   (dir_down),
  .cnt_we     (cnt_we),
  .stat_we    (stat_we),
  .wdata      (wdata),
  .cap_strobe (cap_strobe),
  .remap_en   (remap_en),
  .cnt_rd     (cnt_rd)
);

// File: tb/qenc_counter_test.sv
module qenc_counter_test;
  localparam int W = 32;
  localparam time HALF = 4ns;

  logic clk, rst_n;
  logic enc_a, enc_b, inv_a, inv_b, remap_en;
  logic cnt_we, arr_we, stat_we, cap_strobe;
  logic [W-1:0] wdata;
  logic [W-1:0] cnt_rd, arr_val, cap_val;
  logic upd_flag, dir_down;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [W-1:0] m_cnt, m_arr, m_cap;
  logic m_flag, m_dir;

  qenc_counter #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .inv_a(inv_a), .inv_b(inv_b), .remap_en(remap_en),
    .cnt_we(cnt_we), .arr_we(arr_we), .stat_we(stat_we), .wdata(wdata),
    .cap_strobe(cap_strobe), .cnt_rd(cnt_rd), .arr_val(arr_val),
    .cap_val(cap_val), .upd_flag(upd_flag), .dir_down(dir_down)
  );

  initial clk = 1'b0;
  always #HALF clk = ~clk;

  // Position of a pair in the forward order 00,10,11,01.
  function automatic int pos_of(input logic a, input logic b);
    case ({a, b})
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [W-1:0] exp_read();
    logic [W-1:0] r;
    r = m_cnt;
    if (remap_en) r[W-1] = m_flag;
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "cnt_rd", cnt_rd, exp_read());
    chk(req, "upd_flag", {{(W-1){1'b0}}, upd_flag}, {{(W-1){1'b0}}, m_flag});
    chk(req, "dir_down", {{(W-1){1'b0}}, dir_down}, {{(W-1){1'b0}}, m_dir});
  endtask

  // Model of one channel change as seen after inversion.
  task automatic model_move(input logic na, input logic nb);
    int d;
    d = (pos_of(na ^ inv_a, nb ^ inv_b) - pos_of(enc_a ^ inv_a, enc_b ^ inv_b) + 4) % 4;
    if (d == 1) begin
      m_dir = 1'b0;
      if (m_cnt == m_arr) begin m_cnt = '0; m_flag = 1'b1; end
      else m_cnt = m_cnt + 1;
    end else if (d == 3) begin
      m_dir = 1'b1;
      if (m_cnt == '0) begin m_cnt = m_arr; m_flag = 1'b1; end
      else m_cnt = m_cnt - 1;
    end
  endtask

  task automatic move(input logic na, input logic nb, input string req);
    @(negedge clk);
    model_move(na, nb);
    enc_a = na; enc_b = nb;
    repeat (4) @(negedge clk);
    chk_all(req);
  endtask

  // One step along the physical forward order (raw levels).
  task automatic step_raw(input bit fwd, input string req);
    int p;
    logic na, nb;
    p = (pos_of(enc_a, enc_b) + (fwd ? 1 : 3)) % 4;
    case (p)
      0: {na, nb} = 2'b00;
      1: {na, nb} = 2'b10;
      2: {na, nb} = 2'b11;
      default: {na, nb} = 2'b01;
    endcase
    move(na, nb, req);
  endtask

  task automatic wr_cnt(input logic [W-1:0] v);
    @(negedge clk); cnt_we = 1; wdata = v;
    @(negedge clk); cnt_we = 0; m_cnt = v;
  endtask

  task automatic wr_arr(input logic [W-1:0] v);
    @(negedge clk); arr_we = 1; wdata = v;
    @(negedge clk); arr_we = 0; m_arr = v;
  endtask

  task automatic wr_stat(input logic bit0);
    @(negedge clk); stat_we = 1; wdata = {{(W-1){1'b0}}, bit0};
    @(negedge clk); stat_we = 0;
    if (!bit0) m_flag = 1'b0;
  endtask

  task automatic capture(input string req);
    @(negedge clk); cap_strobe = 1;
    @(negedge clk); cap_strobe = 0; m_cap = m_cnt;
    chk(req, "cap_val", cap_val, m_cap);
  endtask

  initial begin
    #(HALF * 2 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0a1b));
    rst_n = 0; enc_a = 0; enc_b = 0; inv_a = 0; inv_b = 0; remap_en = 0;
    cnt_we = 0; arr_we = 0; stat_we = 0; cap_strobe = 0; wdata = '0;
    m_cnt = '0; m_arr = '1; m_cap = '0; m_flag = 0; m_dir = 0;
    repeat (3) @(negedge clk);
    // R12: reset values while reset is held and after release
    chk("R12", "arr_val", arr_val, '1);
    chk("R12", "cap_val", cap_val, '0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk_all("R12");

    // R1 forward full cycle, R2 reverse
    for (int i = 0; i < 4; i++) step_raw(1, "R1");
    chk("R1", "count after 4", cnt_rd, 32'd4);
    for (int i = 0; i < 2; i++) step_raw(0, "R2");
    chk("R11", "dir after down", {31'd0, dir_down}, 32'd1);

    // R3: both channels change together
    move(~enc_a, ~enc_b, "R3");

    // R4: polarity toggle alone, then reversed direction
    @(negedge clk); inv_a = 1; repeat (4) @(negedge clk); chk_all("R4");
    step_raw(1, "R4");
    chk("R4", "inverted A counts down", {31'd0, dir_down}, 32'd1);
    @(negedge clk); inv_a = 0; inv_b = 1; repeat (4) @(negedge clk); chk_all("R4");
    step_raw(1, "R4");
    @(negedge clk); inv_b = 0;

    // R5 overflow wrap
    wr_arr(32'd3);
    wr_cnt(32'd3);
    step_raw(1, "R5");
    chk("R5", "wrap to zero", cnt_rd, 32'd0);
    // R7 write 1 ignored, write 0 clears
    wr_stat(1); chk_all("R7");
    wr_stat(0); chk_all("R7");
    // R6 underflow wrap
    step_raw(0, "R6");
    chk("R6", "wrap to arr", cnt_rd, 32'd3);
    wr_stat(0);

    // R7 clear colliding with a wrap on the same edge
    wr_cnt(32'd3);
    begin
      int p;
      logic na, nb;
      p = (pos_of(enc_a, enc_b) + 1) % 4;
      case (p)
        0: {na, nb} = 2'b00;
        1: {na, nb} = 2'b10;
        2: {na, nb} = 2'b11;
        default: {na, nb} = 2'b01;
      endcase
      @(negedge clk);
      model_move(na, nb);
      enc_a = na; enc_b = nb;
      @(negedge clk);
      @(negedge clk); stat_we = 1; wdata = '0;
      @(negedge clk); stat_we = 0;
      chk_all("R7");
      chk("R7", "flag survives clear+wrap", {31'd0, upd_flag}, 32'd1);
    end

    // R8 / R9: top bit through the write path and read mirror
    wr_arr('1);
    wr_cnt(32'h8000_0002);
    chk("R9", "native read", cnt_rd, 32'h8000_0002);
    @(negedge clk); remap_en = 1; #1;
    chk("R8", "mirror flag set", cnt_rd, 32'h8000_0002);
    wr_stat(0);
    chk("R8", "mirror flag clear", cnt_rd, 32'h0000_0002);
    wr_cnt(32'h7fff_ffff);
    step_raw(1, "R8");
    chk("R8", "msb hidden", cnt_rd, 32'h0000_0000);
    @(negedge clk); remap_en = 0; #1;
    chk("R9", "msb visible", cnt_rd, 32'h8000_0000);

    // R10 capture
    capture("R10");

    // Random mix with a small reload limit
    wr_arr(32'd6);
    wr_cnt(32'd2);
    wr_stat(0);
    for (int it = 0; it < 600; it++) begin
      int r;
      r = $urandom % 12;
      if (r < 7) step_raw(($urandom % 2) == 1, "R1");
      else if (r == 7) move(~enc_a, ~enc_b, "R3");
      else if (r == 8) begin
        @(negedge clk);
        if ($urandom % 2) inv_a = ~inv_a; else inv_b = ~inv_b;
        repeat (4) @(negedge clk);
        chk_all("R4");
      end
      else if (r == 9) capture("R10");
      else if (r == 10) begin
        @(negedge clk); remap_en = ~remap_en; #1;
        chk_all("R8");
      end
      else begin
        wr_stat($urandom % 2 == 1);
        chk_all("R7");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule